// File: doc/BRIEF.md
# Register-Pair Add/Subtract Unit

This unit performs the 16-bit arithmetic on register pairs for an 8-bit processor core. It covers three kinds of operation:

- A plain add of a 16-bit operand into one of three pointer pairs.
- An add that includes the incoming carry, into the accumulator pair.
- A subtract that includes the incoming borrow, from the accumulator pair.

The surrounding core supplies the current value of the selected pair, the operand and the current flag byte. It raises `start` for one cycle.

On the next clock edge the unit registers three values together:

- the 16-bit result;
- the new flag byte;
- the old pair value plus one, which the core keeps as its internal memory-pointer value.

For the following cycle the unit also raises a single write enable, which names the pair that takes the result. The sum is built one byte at a time with the carry passed between bytes. For this reason the half-carry and the carry always come from the high-byte step.

Top module: `pair_arith16`

## Requirements
- R1: For the plain adds (`op_sel` 0, 1, 2), flag bits S (7), Z (6) and P/V (2) are copied from `flags_in`, and N (bit 1) is cleared.
- R2: For the plain adds, the result is `target_in + operand_in` mod 2^16. H (bit 4) is the carry out of bit 11 and C (bit 0) is the carry out of bit 15.
- R3: For every valid operation, flag bit 5 equals result bit 13 and flag bit 3 equals result bit 11.
- R4: For every valid operation, `memptr_out` becomes `target_in + 1` mod 2^16.
- R5: For the add with carry (`op_sel` 3), the result is `target_in + operand_in + C_in`. S is result bit 15, and Z is set only when all 16 result bits are zero. P/V is 16-bit signed overflow, N is cleared, H is the carry out of bit 11 and C is the carry out of bit 15.
- R6: For the subtract with borrow (`op_sel` 4), the result is `target_in - operand_in - C_in`. N is set and S is result bit 15. Z is set only when the 16-bit result is zero, and P/V is signed overflow. H is the borrow into bit 12 and C is the borrow out of bit 15.
- R7: In the cycle after a valid `start`, exactly one write enable is high. `wr_hl` goes with codes 0, 3 and 4, `wr_ix` with code 1 and `wr_iy` with code 2. All enables are low in every other cycle.
- R8: With `start` high and `op_sel` 5, 6 or 7, all outputs keep their values and no write enable rises.
- R9: While `start` is low, the outputs hold whatever the other inputs do.
- R10: Reset clears the result, the flags, the pointer value and all write enables.
- R11: Results are registered on the clock edge that samples `start`, so they are visible one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 3 | 0 add HL, 1 add IX, 2 add IY, 3 add-with-carry HL, 4 subtract-with-borrow HL |
| target_in | input | 16 | Current value of the selected pair |
| operand_in | input | 16 | Second operand |
| flags_in | input | 8 | Current flag byte (S7 Z6 5 H4 3 P/V2 N1 C0) |
| result_out | output | 16 | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| memptr_out | output | 16 | Registered old target value plus one |
| wr_hl | output | 1 | Write result to HL (one cycle) |
| wr_ix | output | 1 | Write result to IX (one cycle) |
| wr_iy | output | 1 | Write result to IY (one cycle) |

## Verification
All registered results are due one clock edge after the edge that samples `start`, and the write enable belongs only to that following cycle. The bench drives stimulus on the falling edge, so the rising edge in the middle captures it. It then reads every output on the next falling edge, which is half a cycle after the result is registered and before any later stimulus. Invalid codes and idle cycles are checked at the same point against the values sampled just before them.

// File: rtl/pair_arith16_pkg.sv
package pair_arith16_pkg;
  typedef enum logic [2:0] {
    OP_ADD_HL = 3'd0,
    OP_ADD_IX = 3'd1,
    OP_ADD_IY = 3'd2,
    OP_ADC_HL = 3'd3,
    OP_SBC_HL = 3'd4
  } pair_op_e;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_Y  = 5;
  localparam int FB_H  = 4;
  localparam int FB_X  = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_subtracts(input logic [2:0] code);
    return code == OP_SBC_HL;
  endfunction

  function automatic logic op_plain_add(input logic [2:0] code);
    return code <= 3'd2;
  endfunction

  // write enable vector {iy, ix, hl}
  function automatic logic [2:0] op_target(input logic [2:0] code);
    case (code)
      3'd0, 3'd3, 3'd4: return 3'b001;
      3'd1:             return 3'b010;
      3'd2:             return 3'b100;
      default:          return 3'b000;
    endcase
  endfunction

  // signed overflow of a + b where b is already inverted for subtraction
  function automatic logic sum_overflow(input logic a_msb, input logic b_msb,
                                        input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction
endpackage

// File: rtl/pair_slice_chain.sv
module pair_slice_chain #(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cin,
  output logic [DATA_W-1:0] sum_out,
  output logic              top_carry,
  output logic              top_half_carry
);
  localparam int NSLICE = DATA_W / SLICE_W;
  localparam int HALF   = SLICE_W / 2;

  logic [NSLICE:0]   chain;
  logic [NSLICE-1:0] mid_carry;

  assign chain[0] = cin;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [HALF:0] lo_sum;
    logic [HALF:0] hi_sum;
    assign lo_sum = {1'b0, a_in[s*SLICE_W +: HALF]} + {1'b0, b_in[s*SLICE_W +: HALF]}
                  + {{HALF{1'b0}}, chain[s]};
    assign mid_carry[s] = lo_sum[HALF];
    assign hi_sum = {1'b0, a_in[s*SLICE_W+HALF +: HALF]} + {1'b0, b_in[s*SLICE_W+HALF +: HALF]}
                  + {{HALF{1'b0}}, mid_carry[s]};
    assign chain[s+1] = hi_sum[HALF];
    assign sum_out[s*SLICE_W +: SLICE_W] = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};
  end

  assign top_carry      = chain[NSLICE];
  assign top_half_carry = mid_carry[NSLICE-1];
endmodule

// File: rtl/pair_flag_former.sv
module pair_flag_former
  import pair_arith16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        code,
  input  logic [DATA_W-1:0] result,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic              carry,
  input  logic              half_carry,
  input  logic [7:0]        flags_prev,
  output logic [7:0]        flags_new
);
  logic sub, plain;
  assign sub   = op_subtracts(code);
  assign plain = op_plain_add(code);

  always_comb begin
    flags_new        = '0;
    flags_new[FB_Y]  = result[DATA_W-3];
    flags_new[FB_X]  = result[DATA_W-5];
    flags_new[FB_H]  = half_carry ^ sub;
    flags_new[FB_C]  = carry ^ sub;
    flags_new[FB_N]  = sub;
    if (plain) begin
      flags_new[FB_S]  = flags_prev[FB_S];
      flags_new[FB_Z]  = flags_prev[FB_Z];
      flags_new[FB_PV] = flags_prev[FB_PV];
    end else begin
      flags_new[FB_S]  = result[DATA_W-1];
      flags_new[FB_Z]  = (result == '0);
      flags_new[FB_PV] = sum_overflow(a_msb, b_msb, result[DATA_W-1]);
    end
  end
endmodule

// File: rtl/pair_arith16.sv
module pair_arith16
  import pair_arith16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] target_in,
  input  logic [DATA_W-1:0] operand_in,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result_out,
  output logic [7:0]        flags_out,
  output logic [DATA_W-1:0] memptr_out,
  output logic              wr_hl,
  output logic              wr_ix,
  output logic              wr_iy
);
  logic              do_op;
  logic              sub;
  logic [DATA_W-1:0] b_eff;
  logic              cin_eff;
  logic [DATA_W-1:0] sum;
  logic              top_carry, top_half_carry;
  logic [7:0]        flags_next;
  logic [2:0]        we_q;

  assign do_op   = start && op_valid(op_sel);
  assign sub     = op_subtracts(op_sel);
  assign b_eff   = sub ? ~operand_in : operand_in;
  assign cin_eff = op_plain_add(op_sel) ? 1'b0 : (flags_in[FB_C] ^ sub);

  pair_slice_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
    .a_in(target_in), .b_in(b_eff), .cin(cin_eff),
    .sum_out(sum), .top_carry(top_carry), .top_half_carry(top_half_carry)
  );

  pair_flag_former #(.DATA_W(DATA_W)) u_flags (
    .code(op_sel), .result(sum), .a_msb(target_in[DATA_W-1]),
    .b_msb(b_eff[DATA_W-1]), .carry(top_carry), .half_carry(top_half_carry),
    .flags_prev(flags_in), .flags_new(flags_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_out <= '0;
      flags_out  <= '0;
      memptr_out <= '0;
      we_q       <= '0;
    end else begin
      we_q <= '0;
      if (do_op) begin
        result_out <= sum;
        flags_out  <= flags_next;
        memptr_out <= target_in + 1'b1;
        we_q       <= op_target(op_sel);
      end
    end
  end

  assign wr_hl = we_q[0];
  assign wr_ix = we_q[1];
  assign wr_iy = we_q[2];

  assert_plain_keeps_szp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) && $past(op_sel) <= 3'd2 |->
      flags_out[FB_S] == $past(flags_in[FB_S]) && flags_out[FB_Z] == $past(flags_in[FB_Z])
      && flags_out[FB_PV] == $past(flags_in[FB_PV]) && !flags_out[FB_N]);

  assert_copy_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_op) |-> flags_out[FB_Y] == result_out[DATA_W-3]
                     && flags_out[FB_X] == result_out[DATA_W-5]);

  assert_memptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_op) |-> memptr_out == $past(target_in) + 1'b1);

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) && ($past(op_sel) == 3'd3 || $past(op_sel) == 3'd4) |->
      flags_out[FB_Z] == (result_out == '0) && flags_out[FB_S] == result_out[DATA_W-1]);

  assert_sub_sets_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) && $past(op_sel) == 3'd4 |-> flags_out[FB_N]);

  assert_one_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_hl, wr_ix, wr_iy}) && ($countones({wr_hl, wr_ix, wr_iy}) == 1) == $past(do_op));

  assert_bad_code_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && op_sel > 3'd4 |=> $stable(result_out) && $stable(flags_out)
      && $stable(memptr_out) && !wr_hl && !wr_ix && !wr_iy);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result_out) && $stable(flags_out) && $stable(memptr_out));
endmodule

// File: tb/pair_arith16_tb.sv
module pair_arith16_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [15:0] target_in = '0, operand_in = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] result_out, memptr_out;
  logic [7:0]  flags_out;
  logic        wr_hl, wr_ix, wr_iy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_arith16 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .target_in(target_in), .operand_in(operand_in), .flags_in(flags_in),
    .result_out(result_out), .flags_out(flags_out), .memptr_out(memptr_out),
    .wr_hl(wr_hl), .wr_ix(wr_ix), .wr_iy(wr_iy)
  );

  function automatic logic [15:0] pick(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h0FFF;
      6: return 16'h0800;
      7: return 16'h00FF;
      default: return 16'((k * 40503) ^ (k << 7));
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [2:0] op, logic [15:0] t, logic [15:0] o, logic [7:0] f);
    int cin, full, low12, st, so, sr;
    logic [15:0] r;
    logic [7:0] ef;
    logic c, h, v;
    string tag;
    cin = int'(f[0]);
    if (op <= 3'd3) begin
      if (op <= 3'd2) cin = 0;
      full  = int'(t) + int'(o) + cin;
      low12 = int'(t[11:0]) + int'(o[11:0]) + cin;
      c = full > 65535;
      h = low12 > 4095;
      sr = int'($signed(t)) + int'($signed(o)) + cin;
    end else begin
      full  = int'(t) - int'(o) - cin;
      low12 = int'(t[11:0]) - int'(o[11:0]) - cin;
      c = full < 0;
      h = low12 < 0;
      sr = int'($signed(t)) - int'($signed(o)) - cin;
    end
    st = 0; so = 0;
    r = 16'(full);
    v = (sr > 32767) || (sr < -32768);
    ef = 8'h00;
    ef[5] = r[13]; ef[3] = r[11]; ef[4] = h; ef[0] = c;
    if (op <= 3'd2) begin
      ef[7] = f[7]; ef[6] = f[6]; ef[2] = f[2]; ef[1] = 1'b0;
      tag = "R1/R2/R3";
    end else begin
      ef[7] = r[15]; ef[6] = (r == 16'h0); ef[2] = v; ef[1] = (op == 3'd4);
      tag = (op == 3'd3) ? "R5/R3" : "R6/R3";
    end
    @(negedge clk);
    start = 1'b1; op_sel = op; target_in = t; operand_in = o; flags_in = f;
    @(negedge clk);
    start = 1'b0; target_in = ~t; operand_in = ~o; flags_in = ~f;
    check({tag, " result R11"}, 64'(result_out), 64'(r));
    check({tag, " flags"}, 64'(flags_out), 64'(ef));
    check("R4 memptr", 64'(memptr_out), 64'(16'(t + 16'd1)));
    check("R7 enables", 64'({wr_iy, wr_ix, wr_hl}),
          64'({op == 3'd2, op == 3'd1, (op == 3'd0 || op >= 3'd3)}));
    if (st != so) check("internal", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] hold_r, hold_m;
    logic [7:0]  hold_f;
    repeat (3) @(negedge clk);
    check("R10 result", 64'(result_out), 0);
    check("R10 flags", 64'(flags_out), 0);
    check("R10 memptr", 64'(memptr_out), 0);
    check("R10 enables", 64'({wr_iy, wr_ix, wr_hl}), 0);
    rst_n = 1'b1;
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 24; i++)
        for (int j = 0; j < 24; j++)
          run_vec(3'(op), pick(i), pick(j), 8'((i * 29 + j * 7 + op) ^ (j << 3)));
    // R6 borrow chain corner: 0 - 0 - 1
    run_vec(3'd4, 16'h0000, 16'h0000, 8'h01);
    // R5 carry wraps to exactly zero
    run_vec(3'd3, 16'hFFFF, 16'h0000, 8'h01);
    // R8 invalid codes hold everything
    for (int bad = 5; bad < 8; bad++) begin
      hold_r = result_out; hold_f = flags_out; hold_m = memptr_out;
      @(negedge clk);
      start = 1'b1; op_sel = 3'(bad); target_in = 16'h1234; operand_in = 16'h4321; flags_in = 8'hA5;
      @(negedge clk);
      start = 1'b0;
      check("R8 result", 64'(result_out), 64'(hold_r));
      check("R8 flags", 64'(flags_out), 64'(hold_f));
      check("R8 memptr", 64'(memptr_out), 64'(hold_m));
      check("R8 enables", 64'({wr_iy, wr_ix, wr_hl}), 0);
    end
    // R9 idle cycles with moving inputs
    hold_r = result_out; hold_f = flags_out; hold_m = memptr_out;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op_sel = 3'(k); target_in = pick(k); operand_in = pick(k + 9); flags_in = 8'(k * 37);
      check("R9 result", 64'(result_out), 64'(hold_r));
      check("R9 flags", 64'(flags_out), 64'(hold_f));
      check("R9 memptr", 64'(memptr_out), 64'(hold_m));
      check("R9 enables", 64'({wr_iy, wr_ix, wr_hl}), 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule